// File: doc/BRIEF.md
# DMA Channel Run-Control Register File

This block holds the per-channel control and status state of a descriptor-driven DMA engine. A host reaches it over a simple 32-bit register bus with separate read and write strobes. Each channel owns a 128-byte window of word registers. The window holds a status word, a command pointer and three condition-select words. A write-only control port changes the status word through a masked update. The descriptor sequencer watches two per-channel outputs: `run_req`, which says the channel should execute descriptors, and `fetch_req`, a one-cycle pulse that asks it to load the descriptor at `fetch_addr`. Each attached device receives a one-cycle `flush_req` pulse.

A control write carries a 16-bit enable mask in its upper half and new bit values in its lower half. After the merge, the block recomputes the active and dead flags from the run, pause and wake bits. The sequencer reports a fatal descriptor error through `chan_kill`. A kill sets the dead flag and drops the active flag. If a kill and a control write reach the same channel in the same cycle, the kill is applied first and the control write is applied on top of it.

The read port is a small state machine with two states. `RD_IDLE` means no response is pending. `RD_RESP` means `bus_rdata` holds the answer to the read of the previous cycle. A read strobe moves the machine from `RD_IDLE` to `RD_RESP`, or keeps it in `RD_RESP` when reads come back to back. A cycle without a read strobe moves it back to `RD_IDLE`.

Top module: `dmacsr_regfile`

## Requirements
- R1: Reset clears every stored register of every channel to zero. While reset is held, and after it, `run_req`, `flush_req`, `fetch_req` and `bus_rvalid` are low.
- R2: A control write (word index 0) uses data bits 31:16 as a mask and bits 15:0 as values. Only status bits 15 (run), 14 (pause), 13 (flush), 12 (wake) and 7:0 (device status) can change, and only where the mask bit is 1. Bit 11 (dead), bit 10 (active), bit 8 (branch taken) and the remaining bits never take a written value.
- R3: After the merge the block applies three rules in this order. If wake is 1, active is set. If run is 1, active is set and dead is cleared. If pause is 1, active is cleared.
- R4: A control write that takes run from 1 to 0 leaves both active and dead at 0.
- R5: A write to the command-pointer word (index 3) is dropped while run or active is 1. An accepted write stores the data with bits 3:0 forced to zero. On the next cycle it raises that channel's `fetch_req` for exactly one cycle, and `fetch_addr` carries the stored pointer in that cycle.
- R6: `run_req[c]` is high exactly when channel c has run and active both set.
- R7: In the cycle after any control write that leaves the flush bit set, `flush_req[c]` pulses for one cycle. After a control write that leaves flush clear, it stays low.
- R8: A read strobe returns data in the next cycle with `bus_rvalid` high. Index 0 (control) reads zero. Indices 1 (status, in bits 15:0), 3 (command pointer), 4, 5 and 6 (select words) return their stored values. Every other index reads zero. Writes to index 1 and to the other indices have no effect.
- R9: `bus_addr` is a word address. Its bits 6:2 are the word index and the bits above 6 are the channel number. An access to one channel leaves every other channel unchanged.
- R10: `chan_kill[c]` sets dead and clears active on channel c. When a control write reaches the same channel in the same cycle, the kill is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | CH_W+5 | Word address, bits CH_W+6 down to 2 of the byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| chan_kill | input | NUM_CH | Per-channel fatal error from the sequencer |
| run_req | output | NUM_CH | Channel should execute descriptors |
| flush_req | output | NUM_CH | One-cycle flush pulse to the attached device |
| fetch_req | output | NUM_CH | One-cycle descriptor fetch request |
| fetch_addr | output | 32 | Aligned command pointer of the channel that requests a fetch |

## Verification
The overlap that needs care is a sequencer kill and a host control write reaching one channel on the same clock edge. The bench provokes it twice. In the first case the control write sets run on a killed, waking channel, and the result must show run and active with dead cleared. In the second case the control write only changes device status, and dead must survive. Both outcomes are judged by reading the status word back and by watching `run_req`. The bench also checks that a run-clearing write on a dead channel clears dead.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int DATA_W  = 32;
    localparam int STAT_W  = 16;
    localparam int IDX_W   = 5;
    localparam int SEL_N   = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL   = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STAT   = 5'd1;
    localparam logic [IDX_W-1:0] IDX_PTR    = 5'd3;
    localparam logic [IDX_W-1:0] IDX_SEL_IQ = 5'd4;
    localparam logic [IDX_W-1:0] IDX_SEL_BR = 5'd5;
    localparam logic [IDX_W-1:0] IDX_SEL_WT = 5'd6;

    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACTIVE = 10;

    localparam logic [STAT_W-1:0] HOST_BITS = 16'hF0FF;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    // masked merge followed by the derived-flag rules, in their fixed order
    function automatic logic [STAT_W-1:0] ctl_apply(
        input logic [STAT_W-1:0] prev,
        input logic [DATA_W-1:0] wd
    );
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] s;
        en = wd[DATA_W-1:STAT_W] & HOST_BITS;
        s  = (wd[STAT_W-1:0] & en) | (prev & ~en);
        if (s[B_WAKE])  s[B_ACTIVE] = 1'b1;
        if (s[B_RUN]) begin
            s[B_ACTIVE] = 1'b1;
            s[B_DEAD]   = 1'b0;
        end
        if (s[B_PAUSE]) s[B_ACTIVE] = 1'b0;
        if (prev[B_RUN] && !s[B_RUN]) begin
            s[B_ACTIVE] = 1'b0;
            s[B_DEAD]   = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                       bus_wr,
    input  logic [CH_W+6:2]            bus_addr,
    output logic [CH_W-1:0]            ch_idx,
    output logic [IDX_W-1:0]           reg_idx,
    output logic [NUM_CH-1:0]          ctl_wr,
    output logic [NUM_CH-1:0]          ptr_wr,
    output logic [NUM_CH-1:0][SEL_N-1:0] sel_wr
);

    assign ch_idx  = bus_addr[CH_W+6:7];
    assign reg_idx = bus_addr[6:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit       = bus_wr && (ch_idx == CH_W'(c));
        assign ctl_wr[c] = hit && (reg_idx == IDX_CTRL);
        assign ptr_wr[c] = hit && (reg_idx == IDX_PTR);
        for (genvar k = 0; k < SEL_N; k++) begin : g_sel
            assign sel_wr[c][k] = hit && (reg_idx == IDX_SEL_IQ + IDX_W'(k));
        end
    end

endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan
    import dmacsr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr,
    input  logic                          ptr_wr,
    input  logic [SEL_N-1:0]              sel_wr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          kill,
    output logic [STAT_W-1:0]             status,
    output logic [DATA_W-1:0]             cmd_ptr,
    output logic [SEL_N-1:0][DATA_W-1:0]  sel_val,
    output logic                          run_req,
    output logic                          flush_req,
    output logic                          fetch_req
);

    logic [STAT_W-1:0]            status_q, status_d;
    logic [DATA_W-1:0]            ptr_q;
    logic [SEL_N-1:0][DATA_W-1:0] sel_q;
    logic                         flush_q, fetch_q;
    logic                         busy, ptr_ok;

    assign busy   = status_q[B_RUN] | status_q[B_ACTIVE];
    assign ptr_ok = ptr_wr & ~busy;

    always_comb begin
        status_d = status_q;
        if (kill) begin
            status_d[B_DEAD]   = 1'b1;
            status_d[B_ACTIVE] = 1'b0;
        end
        if (ctl_wr) status_d = ctl_apply(status_d, wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            ptr_q    <= '0;
            sel_q    <= '0;
            flush_q  <= 1'b0;
            fetch_q  <= 1'b0;
        end else begin
            status_q <= status_d;
            flush_q  <= ctl_wr & status_d[B_FLUSH];
            fetch_q  <= ptr_ok;
            if (ptr_ok) ptr_q <= {wdata[DATA_W-1:4], 4'b0000};
            for (int k = 0; k < SEL_N; k++) begin
                if (sel_wr[k]) sel_q[k] <= wdata;
            end
        end
    end

    assign status    = status_q;
    assign cmd_ptr   = ptr_q;
    assign sel_val   = sel_q;
    assign run_req   = status_q[B_RUN] & status_q[B_ACTIVE];
    assign flush_req = flush_q;
    assign fetch_req = fetch_q;

    AST_FLUSH_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> $past(ctl_wr)); // R7
    AST_FETCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_q |-> ($past(ptr_wr) && !$past(busy))); // R5
    AST_PTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q)); // R5
    AST_RUN_FALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q[B_RUN]) |-> (!status_q[B_ACTIVE] && !status_q[B_DEAD])); // R4
    AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_wr) && status_q[B_PAUSE]) |-> !status_q[B_ACTIVE]); // R3
    AST_KILL_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !ctl_wr) |=> (status_q[B_DEAD] && !status_q[B_ACTIVE])); // R10

endmodule

// File: rtl/dmacsr_rdmux.sv
module dmacsr_rdmux
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_en,
    input  logic [CH_W-1:0]                       ch_idx,
    input  logic [IDX_W-1:0]                      reg_idx,
    input  logic [NUM_CH-1:0][STAT_W-1:0]         stat_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]         ptr_all,
    input  logic [NUM_CH-1:0][SEL_N-1:0][DATA_W-1:0] sel_all,
    output logic [DATA_W-1:0]                     rdata,
    output logic                                  rvalid
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = '0;
        if (32'(ch_idx) < NUM_CH) begin
            unique case (reg_idx)
                IDX_STAT:   word_d = {{(DATA_W-STAT_W){1'b0}}, stat_all[ch_idx]};
                IDX_PTR:    word_d = ptr_all[ch_idx];
                IDX_SEL_IQ: word_d = sel_all[ch_idx][0];
                IDX_SEL_BR: word_d = sel_all[ch_idx][1];
                IDX_SEL_WT: word_d = sel_all[ch_idx][2];
                default:    word_d = '0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) word_q <= word_d;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RD_IDLE: ;
            RD_RESP: begin
                rvalid = 1'b1;
                rdata  = word_q;
            end
            default: ;
        endcase
    end

    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en)); // R8
    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(rd_en && reg_idx == IDX_CTRL)) |-> (rdata == '0)); // R8

endmodule

// File: rtl/dmacsr_regfile.sv
module dmacsr_regfile
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CH_W+6:2]   bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NUM_CH-1:0] chan_kill,
    output logic [NUM_CH-1:0] run_req,
    output logic [NUM_CH-1:0] flush_req,
    output logic [NUM_CH-1:0] fetch_req,
    output logic [31:0]       fetch_addr
);

    logic [CH_W-1:0]                         ch_idx;
    logic [IDX_W-1:0]                        reg_idx;
    logic [NUM_CH-1:0]                       ctl_wr, ptr_wr;
    logic [NUM_CH-1:0][SEL_N-1:0]            sel_wr;
    logic [NUM_CH-1:0][STAT_W-1:0]           stat_all;
    logic [NUM_CH-1:0][DATA_W-1:0]           ptr_all;
    logic [NUM_CH-1:0][SEL_N-1:0][DATA_W-1:0] sel_all;

    dmacsr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ch_idx  (ch_idx),
        .reg_idx (reg_idx),
        .ctl_wr  (ctl_wr),
        .ptr_wr  (ptr_wr),
        .sel_wr  (sel_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dmacsr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (ctl_wr[c]),
            .ptr_wr   (ptr_wr[c]),
            .sel_wr   (sel_wr[c]),
            .wdata    (bus_wdata),
            .kill     (chan_kill[c]),
            .status   (stat_all[c]),
            .cmd_ptr  (ptr_all[c]),
            .sel_val  (sel_all[c]),
            .run_req  (run_req[c]),
            .flush_req(flush_req[c]),
            .fetch_req(fetch_req[c])
        );
    end

    always_comb begin
        fetch_addr = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (fetch_req[c]) fetch_addr = fetch_addr | ptr_all[c];
        end
    end

    dmacsr_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .ch_idx  (ch_idx),
        .reg_idx (reg_idx),
        .stat_all(stat_all),
        .ptr_all (ptr_all),
        .sel_all (sel_all),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    AST_FETCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_req)); // R9
    AST_RUNREQ_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (run_req == '0 && flush_req == '0)); // R1

endmodule

// File: tb/dmacsr_regfile_test.sv
module dmacsr_regfile_test;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [CH_W+6:2]   bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NUM_CH-1:0] chan_kill = '0;
    logic [NUM_CH-1:0] run_req, flush_req, fetch_req;
    logic [31:0]       fetch_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dmacsr_regfile #(.NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .chan_kill(chan_kill), .run_req(run_req),
        .flush_req(flush_req), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    function automatic logic [CH_W+6:2] wa(input int ch, input int idx);
        return {CH_W'(ch), 5'(idx)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int idx, input logic [31:0] d,
                      input logic [NUM_CH-1:0] k = '0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = wa(ch, idx); bus_wdata = d; chan_kill = k;
        @(negedge clk);
        bus_wr = 1'b0; chan_kill = '0;
    endtask

    task automatic kill(input logic [NUM_CH-1:0] k);
        @(negedge clk);
        chan_kill = k;
        @(negedge clk);
        chan_kill = '0;
    endtask

    task automatic rd(input int ch, input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = wa(ch, idx);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R8: unexpected response 0x%08h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {run_req, flush_req, fetch_req, 3'b0, bus_rvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {run_req, flush_req, fetch_req, 3'b0, bus_rvalid}, 32'h0);
        rd(0, 1, 32'h0, "R1 status ch0");
        rd(2, 3, 32'h0, "R1 pointer ch2");

        // run on channel 1
        wr(1, 0, 32'h8000_8000);
        check("R6 run_req after run", 32'(run_req), 32'h2);
        rd(1, 1, 32'h8400, "R3 run sets active");
        wr(1, 3, 32'hABCD_EF12);
        check("R5 no fetch while busy", 32'(fetch_req), 32'h0);
        rd(1, 3, 32'h0, "R5 pointer held while busy");

        // pause, then clear run
        wr(1, 0, 32'h4000_4000);
        check("R6 run_req paused", 32'(run_req), 32'h0);
        rd(1, 1, 32'hC000, "R3 pause clears active");
        wr(1, 0, 32'hC000_0000);
        rd(1, 1, 32'h0, "R4 run fall");

        // accepted pointer write
        wr(1, 3, 32'h1234_567F);
        check("R5 fetch pulse", 32'(fetch_req), 32'h2);
        check("R5 fetch addr", fetch_addr, 32'h1234_5670);
        @(negedge clk);
        check("R5 fetch one cycle", 32'(fetch_req), 32'h0);
        rd(1, 3, 32'h1234_5670, "R5 pointer aligned");

        // all bits written on channel 0
        wr(0, 0, 32'hFFFF_FFFF);
        check("R7 flush pulse", 32'(flush_req), 32'h1);
        @(negedge clk);
        check("R7 flush one cycle", 32'(flush_req), 32'h0);
        check("R6 paused no run", 32'(run_req), 32'h0);
        rd(0, 1, 32'hF0FF, "R2 host-writable bits only");
        wr(0, 0, 32'h00FF_0011);
        check("R7 sticky flush pulses again", 32'(flush_req), 32'h1);
        rd(0, 1, 32'hF011, "R2 device status update");
        wr(0, 0, 32'hF000_0000);
        check("R7 no flush when cleared", 32'(flush_req), 32'h0);
        rd(0, 1, 32'h0011, "R4 run fall channel 0");

        // mask zero
        wr(3, 0, 32'h00FF_00A5);
        wr(3, 0, 32'h0000_FFFF);
        rd(3, 1, 32'h00A5, "R2 zero mask no change");

        // wake, kill and kill together with control writes
        wr(2, 0, 32'h1000_1000);
        rd(2, 1, 32'h1400, "R3 wake sets active");
        wr(2, 3, 32'h0000_0100);
        check("R5 no fetch while active", 32'(fetch_req), 32'h0);
        kill(4'b0100);
        rd(2, 1, 32'h1800, "R10 kill");
        wr(2, 0, 32'h8000_8000, 4'b0100);
        check("R10 run with kill same cycle", 32'(run_req), 32'h4);
        rd(2, 1, 32'h9400, "R10 kill then run");
        kill(4'b0100);
        check("R10 kill drops run_req", 32'(run_req), 32'h0);
        rd(2, 1, 32'h9800, "R10 kill while running");
        wr(2, 0, 32'h8000_0000);
        rd(2, 1, 32'h1000, "R4 run fall clears dead");
        wr(3, 0, 32'h00FF_005A, 4'b1000);
        rd(3, 1, 32'h085A, "R10 kill with device status write");

        // read-back rules
        wr(0, 1, 32'hFFFF_FFFF);
        rd(0, 1, 32'h0011, "R8 status write ignored");
        rd(0, 0, 32'h0, "R8 control reads zero");
        wr(3, 4, 32'h000F_0003);
        wr(3, 5, 32'h1111_2222);
        wr(3, 6, 32'hDEAD_BEEF);
        rd(3, 4, 32'h000F_0003, "R8 select 4");
        rd(3, 5, 32'h1111_2222, "R8 select 5");
        rd(3, 6, 32'hDEAD_BEEF, "R8 select 6");
        wr(3, 7, 32'hFFFF_FFFF);
        rd(3, 7, 32'h0, "R8 unused index reads zero");
        wr(3, 2, 32'hFFFF_FFFF);
        rd(3, 2, 32'h0, "R8 pointer high reads zero");
        rd(3, 20, 32'h0, "R8 upper window reads zero");
        rd(0, 5, 32'h0, "R9 select not shared");
        rd(1, 1, 32'h0, "R9 channel 1 untouched");
        rd(2, 3, 32'h0, "R9 pointer ch2 untouched");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R8: actual %0d missing responses expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule